// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog timer that counts ticks from a slow watchdog oscillator. The ticks arrive as single-cycle enables in the system clock domain. Software programs the watchdog through one small control register. The register holds a run bit, a key bit and a 3-bit period select. Software must pulse a service strobe often enough to keep the count below the selected period. If it does not, the block raises a one-cycle reset request to the system reset logic.

Once the watchdog is running, it cannot be switched off by a simple write. A register write that sets the key bit and the run bit together opens a short window. Only inside that window does a write of zero to the run bit take effect. The window closes by itself after a fixed number of system clocks.

Top module: `wdt_guard`

## Requirements
- R1: After the asynchronous active-low reset, the run bit, key bit, period select and tick counter are all zero, the readback is zero and the reset request is low.
- R2: A write updates the period select from data bits [2:0] and sets the run bit when data bit 3 is one. The readback returns the key bit at position 4, the run bit at position 3 and the select at [2:0].
- R3: A write with bit 3 at zero while the key window is closed leaves the run bit set.
- R4: A write with both bit 4 and bit 3 at one opens the key window, and the key bit then reads as one. A write with bit 4 set and bit 3 clear does not open it. The key bit falls back to zero by hardware after UNLOCK_CYCLES clocks.
- R5: A write with bit 3 at zero clears the run bit if it occurs in any of the UNLOCK_CYCLES clocks that follow the opening write. A write one clock later has no effect on the run bit.
- R6: From a count of zero, the reset request rises for exactly one clock after 2^(BASE_LOG2+select) ticks. The counter then restarts from zero.
- R7: The service strobe clears the counter. It takes priority over a tick in the same cycle, so that cycle produces no reset request.
- R8: Ticks advance the counter only while the run bit is set. While the run bit is clear, no reset request is made and the count is held. Re-enabling without a service strobe therefore resumes from the held count, and the first timeout comes early.
- R9: A change of period select takes effect at once. If the current count is already at or beyond the new period, the next tick raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write data: key [4], run [3], period select [2:0] |
| kick | input | 1 | Service strobe that clears the counter |
| tick | input | 1 | Watchdog oscillator tick, one system clock wide |
| rd_data | output | 5 | Control register readback, same layout as wr_data |
| rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The bench builds the block with BASE_LOG2 set to 3. All eight period codes then time out after 8 to 1024 ticks, so every select value, period switches that leave the count beyond the new limit, and many back-to-back timeouts all fit in a few thousand cycles. UNLOCK_CYCLES stays at its default of 4. This lets the bench probe the last clock inside the key window and the first clock outside it.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int SEL_W = 3;

    typedef struct packed {
        logic             unlock;
        logic             en;
        logic [SEL_W-1:0] sel;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
    import wdt_guard_pkg::*;
#(
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  wdt_ctrl_t        wr_i,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output wdt_ctrl_t        rd_o
);

    localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [WIN_W-1:0] win;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     open_q;

    assign open_q = (st_q.win != '0);

    always_comb begin
        st_d = st_q;
        if (open_q) begin
            st_d.win = st_q.win - 1'b1;
        end
        if (wr_en_i) begin
            st_d.sel = wr_i.sel;
            if (wr_i.en) begin
                st_d.en = 1'b1;
            end else if (open_q) begin
                st_d.en = 1'b0;
            end
            if (wr_i.unlock && wr_i.en) begin
                st_d.win = WIN_W'(UNLOCK_CYCLES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign sel_o = st_q.sel;

    always_comb begin
        rd_o        = '0;
        rd_o.unlock = open_q;
        rd_o.en     = st_q.en;
        rd_o.sel    = st_q.sel;
    end

    // R3: a zero write outside the window keeps the run bit
    p_plain_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_i.en && !open_q && st_q.en) |=> st_q.en);

    // R4: window counter never exceeds its programmed length
    p_window_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win <= WIN_W'(UNLOCK_CYCLES));

    // R4: the window only opens after a key write with run bit set
    p_window_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(wr_en_i && wr_i.unlock && wr_i.en));

    // R5: the run bit only falls while the window was open
    p_guarded_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.en) |-> $past(open_q));

endmodule

// File: rtl/wdt_guard_limit.sv
module wdt_guard_limit
    import wdt_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] term_o
);

    localparam int CODES = 1 << SEL_W;

    logic [CNT_W-1:0] term_lut [CODES];

    for (genvar g = 0; g < CODES; g++) begin : g_term
        assign term_lut[g] = {CNT_W{1'b1}} >> (CODES - 1 - g);
    end

    assign term_o = term_lut[sel_i];

endmodule

// File: rtl/wdt_guard_count.sv
module wdt_guard_count #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step_w;
    logic    expire_w;

    assign step_w   = en_i && tick_i && !kick_i;
    assign expire_w = (st_q.cnt >= term_i);

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (kick_i) begin
            st_d.cnt = '0;
        end else if (step_w) begin
            if (expire_w) begin
                st_d.cnt = '0;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

    // R6: the request lasts one clock
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req);

    // R7: the service strobe always leaves a zero count
    p_kick_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.cnt == '0));

    // R8: a request needs a tick while running and no strobe
    p_req_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> $past(en_i && tick_i && !kick_i));

    // R8: without a running tick or a strobe the count holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick_i && !(en_i && tick_i)) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_LOG2     = 14,
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              kick,
    input  logic              tick,
    output logic [CTRL_W-1:0] rd_data,
    output logic              rst_req
);

    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

    wdt_ctrl_t        wr_s;
    wdt_ctrl_t        rd_s;
    logic             en_s;
    logic [SEL_W-1:0] sel_s;
    logic [CNT_W-1:0] term_s;

    assign wr_s    = wdt_ctrl_t'(wr_data);
    assign rd_data = rd_s;

    wdt_guard_ctrl #(
        .UNLOCK_CYCLES(UNLOCK_CYCLES)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en),
        .wr_i   (wr_s),
        .en_o   (en_s),
        .sel_o  (sel_s),
        .rd_o   (rd_s)
    );

    wdt_guard_limit #(
        .BASE_LOG2(BASE_LOG2),
        .CNT_W    (CNT_W)
    ) u_limit (
        .sel_i (sel_s),
        .term_o(term_s)
    );

    wdt_guard_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_s),
        .tick_i(tick),
        .kick_i(kick),
        .term_i(term_s),
        .req_o (rst_req)
    );

    // R8: no request while the run bit reads clear
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(rd_data[3]));

endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;

    localparam int BASE = 3;
    localparam int WIN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic       kick = 1'b0;
    logic       tick = 1'b0;
    logic [4:0] rd_data;
    logic       rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_en, m_sel, m_win, m_cnt, m_rst;

    wdt_guard #(.BASE_LOG2(BASE), .UNLOCK_CYCLES(WIN)) u_wdt_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .kick(kick), .tick(tick), .rd_data(rd_data), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    function automatic int exp_rd();
        return ((m_win > 0) ? 16 : 0) + (m_en * 8) + m_sel;
    endfunction

    function automatic int period(input int sel);
        return 1 << (BASE + sel);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update(input bit we, input int d, input bit k, input bit t);
        int old_win;
        m_rst = 0;
        if (k) m_cnt = 0;
        else if (m_en != 0 && t) begin
            if (m_cnt + 1 >= period(m_sel)) begin
                m_cnt = 0;
                m_rst = 1;
            end else m_cnt++;
        end
        old_win = m_win;
        if (m_win > 0) m_win--;
        if (we) begin
            m_sel = d & 7;
            if (d[3]) m_en = 1;
            else if (old_win > 0) m_en = 0;
            if (d[4] && d[3]) m_win = WIN;
        end
    endtask

    task automatic step(input bit we, input logic [4:0] d, input bit k, input bit t);
        @(negedge clk);
        wr_en = we; wr_data = d; kick = k; tick = t;
        @(posedge clk);
        model_update(we, int'(d), k, t);
        #1;
        check("R2 readback", int'(rd_data), exp_rd());
        check("R6 reset request", int'(rst_req), m_rst);
    endtask

    task automatic idle();
        step(1'b0, 5'h00, 1'b0, 1'b0);
    endtask

    task automatic ticks_to_reset(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            step(1'b0, 5'h00, 1'b0, 1'b1);
            if (rst_req) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        m_en = 0; m_sel = 0; m_win = 0; m_cnt = 0; m_rst = 0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        check("R1 readback after reset", int'(rd_data), 0);
        check("R1 request after reset", int'(rst_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: field placement
        step(1'b1, 5'h0D, 1'b0, 1'b0);
        check("R2 run and select", int'(rd_data), 13);
        // R6: period code 0 from a cleared count
        step(1'b1, 5'h08, 1'b1, 1'b0);
        ticks_to_reset(100, n);
        check("R6 ticks to first timeout", n, 8);
        idle();
        check("R6 request one clock wide", int'(rst_req), 0);
        ticks_to_reset(100, n);
        check("R6 restart after timeout", n, 8);

        // R3: plain zero write
        step(1'b1, 5'h00, 1'b0, 1'b0);
        check("R3 run bit kept", int'(rd_data[3]), 1);

        // R4: key bit alone opens nothing; key with run opens the window
        step(1'b1, 5'h10, 1'b0, 1'b0);
        check("R4 key without run", int'(rd_data[4]), 0);
        step(1'b1, 5'h18, 1'b0, 1'b0);
        check("R4 window open", int'(rd_data[4]), 1);
        for (int i = 0; i < WIN - 1; i++) idle();
        check("R4 window last clock", int'(rd_data[4]), 1);
        idle();
        check("R4 window closed by hardware", int'(rd_data[4]), 0);

        // R5: clearing write on the last window clock
        step(1'b1, 5'h18, 1'b0, 1'b0);
        for (int i = 0; i < WIN - 1; i++) idle();
        step(1'b1, 5'h00, 1'b0, 1'b0);
        check("R5 cleared inside window", int'(rd_data[3]), 0);
        step(1'b1, 5'h08, 1'b0, 1'b0);
        step(1'b1, 5'h18, 1'b0, 1'b0);
        for (int i = 0; i < WIN; i++) idle();
        step(1'b1, 5'h00, 1'b0, 1'b0);
        check("R5 late clear ignored", int'(rd_data[3]), 1);

        // R8: disabled hold and early timeout
        step(1'b1, 5'h08, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 5'h00, 1'b0, 1'b1);
        step(1'b1, 5'h18, 1'b0, 1'b0);
        step(1'b1, 5'h00, 1'b0, 1'b0);
        check("R8 disabled", int'(rd_data[3]), 0);
        n = 0;
        for (int i = 0; i < 50; i++) begin
            step(1'b0, 5'h00, 1'b0, 1'b1);
            n += int'(rst_req);
        end
        check("R8 no request while disabled", n, 0);
        step(1'b1, 5'h08, 1'b0, 1'b0);
        ticks_to_reset(100, n);
        check("R8 early timeout from held count", n, 3);

        // R7: strobe beats tick
        step(1'b0, 5'h00, 1'b1, 1'b0);
        for (int i = 0; i < 7; i++) step(1'b0, 5'h00, 1'b0, 1'b1);
        step(1'b0, 5'h00, 1'b1, 1'b1);
        check("R7 strobe wins over tick", int'(rst_req), 0);
        ticks_to_reset(100, n);
        check("R7 full period after strobe", n, 8);

        // R9: shrink the period below the current count
        step(1'b1, 5'h0B, 1'b1, 1'b0);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b0, 5'h00, 1'b0, 1'b1);
            n += int'(rst_req);
        end
        check("R9 no request below long period", n, 0);
        step(1'b1, 5'h08, 1'b0, 1'b0);
        step(1'b0, 5'h00, 1'b0, 1'b1);
        check("R9 immediate timeout after shrink", int'(rst_req), 1);

        // random mix against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < 6000; i++) begin
            bit we, k, t;
            logic [4:0] d;
            we = ($urandom % 60) == 0;
            k  = ($urandom % 400) == 0;
            t  = ($urandom % 4) != 0;
            d  = 5'($urandom);
            if (d[2:0] > 3'd3) d[2] = 1'b0;
            step(we, d, k, t);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule